// File: doc/BRIEF.md
# Buffered One-Time-Program Write Controller

This block is the command layer for writing an add-only memory. A bit-slot layer below it turns bus traffic into single-cycle events: a received byte, a request for the next byte to send back, a bus reset, and the completion of an external program pulse. The controller runs two write sequences. One programs the 128-byte main array in 8-byte segments through a staging buffer. The other programs a small status array one byte at a time, with a read-back after each byte. Programming can only clear bits: the staged value is ANDed into what is already stored.

The host checks the transfer from CRC-8 bytes that the controller returns. The CRC uses the polynomial x^8+x^5+x^4+1, shifts data LSB first (reflected constant 8Ch) and starts from 00h unless stated otherwise. Only the host decides whether to continue after a bad CRC or a bad read-back. The controller checks nothing except the address and the command bytes. Status byte 0 holds one write-protect bit per main-array page. Status bytes 1 to 4 are redirection bytes: software may store values in them, but the controller never acts on them. Both arrays can be read at any time through combinational read ports.

Top module: `otp_write_ctrl`

## Requirements
- R1: After reset every main-array byte reads FFh, status bytes 0 to 6 read FFh, status byte 7 reads 00h and txValid is low.
- R2: Command byte 0Fh, then an address low byte, then an address high byte. The next byte request returns the CRC-8 of those three bytes, starting from 00h.
- R3: After that CRC the next eight received bytes fill the staging buffer. The following byte request returns the CRC-8 of only those eight bytes, starting from 00h.
- R4: After a received 5Ah and then a program strobe, main byte base+i becomes its old value AND buffer byte i, for i = 0 to 7. Here base is the start address.
- R5: Main-array page p (bytes 32p to 32p+31) is protected when bit p of status byte 0 reads 0. A program strobe aimed at a protected page changes nothing. The page can still be read.
- R6: A write-memory start address is valid only when the high byte is 00h, the low byte is below 80h and its three low bits are 0. A write-status address is valid only when the high byte is 00h and the low byte is below 8. After an invalid address, every byte request returns FFh and nothing is programmed until a bus reset.
- R7: Command byte 55h, then an address low byte, an address high byte and one data byte. The next byte request returns the CRC-8 of all four bytes. After a 5Ah and a strobe, the status byte at that address becomes its old value AND the data byte.
- R8: After a status byte is programmed, the next byte request returns that byte as it is now stored. The address then increments whether or not the stored byte matches the data byte. The next data byte goes into a CRC preset to the new address low byte, and the next byte request returns that CRC. A 5Ah and a strobe then program the new byte.
- R9: Status byte 7 always reads 00h and no write changes it. The value in the redirection bytes (status 1 to 4) has no effect on programming the main array.
- R10: A bus reset at any point before the strobe abandons the sequence and changes no memory. A strobe that does not follow an accepted 5Ah is ignored. A byte other than 5Ah where 5Ah is expected ends the sequence without programming.
- R11: A first byte after bus reset other than 0Fh or 55h makes the controller ignore all bytes and strobes until the next bus reset. Byte requests then return FFh.
- R12: Every byte request is answered in the following cycle by txValid high for exactly one cycle. txByte is FFh when no CRC or read-back byte is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; puts both arrays in their unprogrammed state |
| busReset | input | 1 | One-cycle pulse: a reset was seen on the bus |
| rxValid | input | 1 | One-cycle pulse: rxByte holds a byte from the host |
| rxByte | input | 8 | Received byte |
| txReq | input | 1 | One-cycle pulse: the host starts reading one byte |
| progStrobe | input | 1 | One-cycle pulse: the external program pulse has completed |
| txValid | output | 1 | High for one cycle after txReq |
| txByte | output | 8 | Byte returned to the host |
| rdMemAddr | input | 7 | Main-array read address |
| rdMemData | output | 8 | Main-array byte at rdMemAddr |
| rdStatAddr | input | 3 | Status-array read address |
| rdStatData | output | 8 | Status byte at rdStatAddr |

## Verification
Some properties are checked by assertions on every cycle. A stored bit of either array never returns from 0 to 1. A strobe aimed at a locked page leaves the segment untouched. A bus reset always brings the sequence back to idle. At most one source drives the reply byte in any cycle. The bench scenarios cover the rest: the exact CRC values, the AND merge, the preset of the CRC from the new address, the address moving on after a failed read-back, and the effect of bad addresses, stray strobes and aborted sequences. Each scenario is compared against a memory model and a CRC function inside the bench.

// File: rtl/otp_wr_pkg.sv
package otp_wr_pkg;
  localparam logic [7:0] CMD_WR_MEM  = 8'h0F;
  localparam logic [7:0] CMD_WR_STAT = 8'h55;
  localparam logic [7:0] CMD_PROGRAM = 8'h5A;
  localparam logic [7:0] CRC_POLY_R  = 8'h8C;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MLO, ST_MHI, ST_MCRC1, ST_MDATA, ST_MCRC2, ST_MCMD, ST_MARM,
    ST_SLO, ST_SHI, ST_SDATA, ST_SCRC, ST_SCMD, ST_SARM, ST_SVER, ST_DEAD
  } seqState_t;

  typedef struct packed {
    logic crcClear;
    logic crcPreset;
    logic crcShift;
    logic addrLoLoad;
    logic addrHiLoad;
    logic bufWrite;
    logic memProgram;
    logic statProgram;
    logic addrInc;
    logic txCrc;
    logic txStat;
    logic txOnes;
  } ctlStrb_t;

  function automatic logic [7:0] crc8Step(input logic [7:0] crcIn, input logic [7:0] dataIn);
    logic [7:0] c;
    logic fb;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ dataIn[i];
      c = c >> 1;
      if (fb) c = c ^ CRC_POLY_R;
    end
    return c;
  endfunction
endpackage

// File: rtl/otp_wr_ctrl.sv
module otp_wr_ctrl
  import otp_wr_pkg::*;
#(
  parameter int SEG_BYTES = 8,
  localparam int SEG_AW = $clog2(SEG_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              txReq,
  input  logic              progStrobe,
  input  logic              addrMemOk,
  input  logic              addrStatOk,
  output ctlStrb_t          strb,
  output logic [SEG_AW-1:0] bufIdx
);
  seqState_t state, nxt;
  logic [SEG_AW-1:0] cnt;

  assign bufIdx = cnt;

  always_comb begin
    strb = '0;
    nxt = state;
    if (txReq) strb.txOnes = 1'b1;
    unique case (state)
      ST_IDLE: if (rxValid) begin
        if (rxByte == CMD_WR_MEM) begin nxt = ST_MLO; strb.crcShift = 1'b1; end
        else if (rxByte == CMD_WR_STAT) begin nxt = ST_SLO; strb.crcShift = 1'b1; end
        else nxt = ST_DEAD;
      end
      ST_MLO, ST_SLO: if (rxValid) begin
        strb.addrLoLoad = 1'b1;
        strb.crcShift = 1'b1;
        nxt = (state == ST_MLO) ? ST_MHI : ST_SHI;
      end
      ST_MHI, ST_SHI: if (rxValid) begin
        strb.addrHiLoad = 1'b1;
        strb.crcShift = 1'b1;
        nxt = (state == ST_MHI) ? ST_MCRC1 : ST_SDATA;
      end
      ST_MCRC1: begin
        if (!addrMemOk) nxt = ST_DEAD;
        else if (txReq) begin
          strb.txOnes = 1'b0;
          strb.txCrc = 1'b1;
          strb.crcClear = 1'b1;
          nxt = ST_MDATA;
        end
      end
      ST_MDATA: if (rxValid) begin
        strb.bufWrite = 1'b1;
        strb.crcShift = 1'b1;
        if (cnt == SEG_AW'(SEG_BYTES - 1)) nxt = ST_MCRC2;
      end
      ST_MCRC2, ST_SCRC: if (txReq) begin
        strb.txOnes = 1'b0;
        strb.txCrc = 1'b1;
        nxt = (state == ST_MCRC2) ? ST_MCMD : ST_SCMD;
      end
      ST_MCMD, ST_SCMD: if (rxValid) begin
        if (rxByte != CMD_PROGRAM) nxt = ST_DEAD;
        else nxt = (state == ST_MCMD) ? ST_MARM : ST_SARM;
      end
      ST_MARM: if (progStrobe) begin
        strb.memProgram = 1'b1;
        nxt = ST_DEAD;
      end
      ST_SDATA: begin
        if (!addrStatOk) nxt = ST_DEAD;
        else if (rxValid) begin
          strb.bufWrite = 1'b1;
          strb.crcShift = 1'b1;
          nxt = ST_SCRC;
        end
      end
      ST_SARM: if (progStrobe) begin
        strb.statProgram = 1'b1;
        nxt = ST_SVER;
      end
      ST_SVER: if (txReq) begin
        strb.txOnes = 1'b0;
        strb.txStat = 1'b1;
        strb.addrInc = 1'b1;
        strb.crcPreset = 1'b1;
        nxt = ST_SDATA;
      end
      default: nxt = ST_DEAD;
    endcase
    if (busReset) begin
      strb = '0;
      strb.txOnes = txReq;
      strb.crcClear = 1'b1;
      nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt <= '0;
    end else begin
      state <= nxt;
      if (busReset || strb.crcClear) cnt <= '0;
      else if (state == ST_MDATA && rxValid) cnt <= cnt + 1'b1;
    end
  end

  AST_BUS_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (state == ST_IDLE)); // R10
endmodule

// File: rtl/otp_wr_dpath.sv
module otp_wr_dpath
  import otp_wr_pkg::*;
#(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 32,
  parameter int SEG_BYTES  = 8,
  parameter int STAT_BYTES = 8,
  localparam int MEM_AW  = $clog2(MEM_BYTES),
  localparam int PAGE_AW = $clog2(PAGE_BYTES),
  localparam int SEG_AW  = $clog2(SEG_BYTES),
  localparam int STAT_AW = $clog2(STAT_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrb_t           strb,
  input  logic [SEG_AW-1:0]  bufIdx,
  input  logic [7:0]         rxByte,
  output logic               addrMemOk,
  output logic               addrStatOk,
  output logic               txValid,
  output logic [7:0]         txByte,
  input  logic [MEM_AW-1:0]  rdMemAddr,
  output logic [7:0]         rdMemData,
  input  logic [STAT_AW-1:0] rdStatAddr,
  output logic [7:0]         rdStatData
);
  logic [7:0] addrLo, addrHi, crcReg, nextLo;
  logic [7:0] bufArr  [SEG_BYTES];
  logic [7:0] memArr  [MEM_BYTES];
  logic [7:0] statArr [STAT_BYTES-1];
  logic [MEM_AW-1:0] segBase;
  logic [MEM_AW-PAGE_AW-1:0] pageIdx;
  logic pageLocked;
  logic [7:0] segHead;

  function automatic logic [7:0] statRead(input logic [STAT_AW-1:0] idx);
    if (int'(idx) < STAT_BYTES - 1) return statArr[idx];
    return 8'h00;
  endfunction

  assign nextLo     = addrLo + 8'd1;
  assign segBase    = {addrLo[MEM_AW-1:SEG_AW], {SEG_AW{1'b0}}};
  assign pageIdx    = addrLo[MEM_AW-1:PAGE_AW];
  assign pageLocked = !statArr[0][pageIdx];
  assign segHead    = memArr[segBase];
  assign addrMemOk  = (addrHi == 8'h00) && (addrLo < 8'(MEM_BYTES)) &&
                      (addrLo[SEG_AW-1:0] == '0);
  assign addrStatOk = (addrHi == 8'h00) && (addrLo < 8'(STAT_BYTES));
  assign rdMemData  = memArr[rdMemAddr];
  assign rdStatData = statRead(rdStatAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo <= '0;
      addrHi <= '0;
      crcReg <= '0;
      txValid <= 1'b0;
      txByte <= 8'hFF;
      for (int i = 0; i < SEG_BYTES; i++) bufArr[i] <= 8'hFF;
      for (int i = 0; i < MEM_BYTES; i++) memArr[i] <= 8'hFF;
      for (int i = 0; i < STAT_BYTES - 1; i++) statArr[i] <= 8'hFF;
    end else begin
      if (strb.crcClear) crcReg <= 8'h00;
      else if (strb.crcPreset) crcReg <= nextLo;
      else if (strb.crcShift) crcReg <= crc8Step(crcReg, rxByte);
      if (strb.addrLoLoad) addrLo <= rxByte;
      if (strb.addrHiLoad) addrHi <= rxByte;
      if (strb.addrInc) {addrHi, addrLo} <= {addrHi, addrLo} + 16'd1;
      if (strb.bufWrite) bufArr[bufIdx] <= rxByte;
      if (strb.memProgram && !pageLocked)
        for (int i = 0; i < SEG_BYTES; i++)
          memArr[segBase + MEM_AW'(i)] <= memArr[segBase + MEM_AW'(i)] & bufArr[i];
      if (strb.statProgram && (addrLo < 8'(STAT_BYTES - 1)))
        statArr[addrLo[STAT_AW-1:0]] <= statArr[addrLo[STAT_AW-1:0]] & bufArr[0];
      txValid <= strb.txCrc | strb.txStat | strb.txOnes;
      if (strb.txCrc) txByte <= crcReg;
      else if (strb.txStat) txByte <= statRead(addrLo[STAT_AW-1:0]);
      else if (strb.txOnes) txByte <= 8'hFF;
    end
  end

  AST_MEM_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $stable(rdMemAddr) |-> ((rdMemData & ~$past(rdMemData)) == 8'h00)); // R4
  AST_STAT_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $stable(rdStatAddr) |-> ((rdStatData & ~$past(rdStatData)) == 8'h00)); // R7
  AST_LOCKED_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.memProgram && pageLocked) |=> $stable(segHead)); // R5
  AST_TX_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txCrc, strb.txStat, strb.txOnes})); // R12
endmodule

// File: rtl/otp_write_ctrl.sv
module otp_write_ctrl
  import otp_wr_pkg::*;
#(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 32,
  parameter int SEG_BYTES  = 8,
  parameter int STAT_BYTES = 8,
  localparam int MEM_AW  = $clog2(MEM_BYTES),
  localparam int SEG_AW  = $clog2(SEG_BYTES),
  localparam int STAT_AW = $clog2(STAT_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busReset,
  input  logic               rxValid,
  input  logic [7:0]         rxByte,
  input  logic               txReq,
  input  logic               progStrobe,
  output logic               txValid,
  output logic [7:0]         txByte,
  input  logic [MEM_AW-1:0]  rdMemAddr,
  output logic [7:0]         rdMemData,
  input  logic [STAT_AW-1:0] rdStatAddr,
  output logic [7:0]         rdStatData
);
  ctlStrb_t strb;
  logic [SEG_AW-1:0] bufIdx;
  logic addrMemOk, addrStatOk;

  otp_wr_ctrl #(.SEG_BYTES(SEG_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid), .rxByte(rxByte),
    .txReq(txReq), .progStrobe(progStrobe), .addrMemOk(addrMemOk),
    .addrStatOk(addrStatOk), .strb(strb), .bufIdx(bufIdx)
  );

  otp_wr_dpath #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
                 .SEG_BYTES(SEG_BYTES), .STAT_BYTES(STAT_BYTES)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .bufIdx(bufIdx), .rxByte(rxByte),
    .addrMemOk(addrMemOk), .addrStatOk(addrStatOk), .txValid(txValid), .txByte(txByte),
    .rdMemAddr(rdMemAddr), .rdMemData(rdMemData), .rdStatAddr(rdStatAddr),
    .rdStatData(rdStatData)
  );
endmodule

// File: tb/otp_write_ctrl_tb.sv
module otp_write_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, busReset = 1'b0, rxValid = 1'b0, txReq = 1'b0, progStrobe = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic txValid;
  logic [7:0] txByte, rdMemData, rdStatData;
  logic [6:0] rdMemAddr = '0;
  logic [2:0] rdStatAddr = '0;

  int errors = 0, checks = 0;
  logic [7:0] mMem [128];
  logic [7:0] mStat [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  otp_write_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid), .rxByte(rxByte),
    .txReq(txReq), .progStrobe(progStrobe), .txValid(txValid), .txByte(txByte),
    .rdMemAddr(rdMemAddr), .rdMemData(rdMemData), .rdStatAddr(rdStatAddr),
    .rdStatData(rdStatData)
  );

  function automatic logic [7:0] crcB(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic readByte(output logic [7:0] b);
    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0;
    b = txByte;
    check("R12 txValid after request", {7'd0, txValid}, 8'd1);
  endtask

  task automatic pulseStrobe();
    @(negedge clk); progStrobe = 1'b1;
    @(negedge clk); progStrobe = 1'b0;
  endtask

  task automatic pulseBusReset();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic compareMem(input string tag);
    int bad = 0;
    logic [7:0] firstAct = 0, firstExp = 0;
    for (int a = 0; a < 128; a++) begin
      rdMemAddr = 7'(a); #1;
      if (rdMemData !== mMem[a] && bad == 0) begin firstAct = rdMemData; firstExp = mMem[a]; end
      if (rdMemData !== mMem[a]) bad++;
    end
    check(tag, firstAct, firstExp);
  endtask

  task automatic compareStat(input string tag);
    int bad = 0;
    logic [7:0] firstAct = 0, firstExp = 0;
    for (int a = 0; a < 8; a++) begin
      rdStatAddr = 3'(a); #1;
      if (rdStatData !== mStat[a] && bad == 0) begin firstAct = rdStatData; firstExp = mStat[a]; end
      if (rdStatData !== mStat[a]) bad++;
    end
    check(tag, firstAct, firstExp);
  endtask

  // Full write-memory sequence; abortAt: 0 none, 1 bus reset before 5Ah, 2 strobe without 5Ah, 3 wrong byte instead of 5Ah
  task automatic memWrite(input logic [7:0] lo, input logic [63:0] dat, input int abortAt);
    logic [7:0] c, got;
    c = crcB(crcB(crcB(8'h00, 8'h0F), lo), 8'h00);
    sendByte(8'h0F); sendByte(lo); sendByte(8'h00);
    readByte(got); check("R2 header CRC", got, c);
    c = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sendByte(dat[8*i +: 8]);
      c = crcB(c, dat[8*i +: 8]);
    end
    readByte(got); check("R3 data CRC", got, c);
    if (abortAt == 1) pulseBusReset();
    if (abortAt == 3) sendByte(8'hA5);
    else if (abortAt != 2) sendByte(8'h5A);
    pulseStrobe();
    if (abortAt == 0 && mStat[0][lo[6:5]])
      for (int i = 0; i < 8; i++) mMem[lo[6:0] + 7'(i)] &= dat[8*i +: 8];
    pulseBusReset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] got, c;
    logic [63:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) mMem[i] = 8'hFF;
    for (int i = 0; i < 7; i++) mStat[i] = 8'hFF;
    mStat[7] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 txValid low after reset", {7'd0, txValid}, 8'd0);
    compareMem("R1 main array erased");
    compareStat("R1 status defaults");

    // R2 R3 R4 directed segment at 0
    memWrite(8'h00, 64'h0123_4567_89AB_CDEF, 0);
    compareMem("R4 AND merge at segment 0");
    memWrite(8'h00, 64'hFF00_FF00_F0F0_0F0F, 0);
    compareMem("R4 second merge only clears");
    @(negedge clk);
    check("R12 txValid one cycle", {7'd0, txValid}, 8'd0);

    // random segments
    for (int n = 0; n < 20; n++) begin
      d = {$urandom, $urandom} | {$urandom, $urandom};
      memWrite(8'($urandom_range(0, 15) * 8), d, (n % 5 == 4) ? 1 : 0);
    end
    compareMem("R4 random segment writes");

    // R10 aborts and stray strobe
    memWrite(8'h40, 64'h0, 1);
    memWrite(8'h48, 64'h0, 2);
    memWrite(8'h50, 64'h0, 3);
    compareMem("R10 abort, stray strobe, wrong program byte");

    // R6 invalid addresses
    sendByte(8'h0F); sendByte(8'h03); sendByte(8'h00);
    readByte(got); check("R6 misaligned address reply", got, 8'hFF);
    for (int i = 0; i < 8; i++) sendByte(8'h00);
    sendByte(8'h5A); pulseStrobe(); pulseBusReset();
    sendByte(8'h0F); sendByte(8'h80); sendByte(8'h00);
    readByte(got); check("R6 out-of-range address reply", got, 8'hFF);
    sendByte(8'h0F); sendByte(8'h08); sendByte(8'h01);
    readByte(got); check("R6 nonzero high byte reply", got, 8'hFF);
    pulseBusReset();
    compareMem("R6 invalid address programs nothing");

    // R11 unknown command
    sendByte(8'h33);
    readByte(got); check("R11 unknown command reply", got, 8'hFF);
    sendByte(8'h0F); sendByte(8'h00); sendByte(8'h00);
    for (int i = 0; i < 8; i++) sendByte(8'h00);
    sendByte(8'h5A); pulseStrobe(); pulseBusReset();
    compareMem("R11 bytes ignored until bus reset");

    // R7 R9: program redirection byte 1, then confirm page 1 write unaffected
    sendByte(8'h55); sendByte(8'h01); sendByte(8'h00); sendByte(8'h00);
    readByte(got);
    check("R7 status CRC", got, crcB(crcB(crcB(crcB(8'h00, 8'h55), 8'h01), 8'h00), 8'h00));
    sendByte(8'h5A); pulseStrobe(); mStat[1] = 8'h00;
    readByte(got); check("R8 read-back of status 1", got, 8'h00);
    pulseBusReset();
    memWrite(8'h20, 64'h1111_2222_3333_4444, 0);
    compareMem("R9 redirection byte has no effect");

    // R8 mismatch at byte 3 then continue into byte 4
    sendByte(8'h55); sendByte(8'h03); sendByte(8'h00); sendByte(8'h0F);
    readByte(got); sendByte(8'h5A); pulseStrobe(); mStat[3] = 8'h0F;
    readByte(got); check("R8 read-back status 3", got, 8'h0F);
    pulseBusReset();
    sendByte(8'h55); sendByte(8'h03); sendByte(8'h00); sendByte(8'hF0);
    readByte(got); sendByte(8'h5A); pulseStrobe(); mStat[3] = 8'h00;
    readByte(got); check("R8 mismatching read-back", got, 8'h00);
    sendByte(8'hC3);
    readByte(got); check("R8 CRC preset by new address", got, crcB(8'h04, 8'hC3));
    sendByte(8'h5A); pulseStrobe(); mStat[4] = 8'hC3;
    readByte(got); check("R8 read-back status 4", got, 8'hC3);
    pulseBusReset();
    compareStat("R8 status after incrementing writes");

    // R9 byte 7 fixed, then address past end
    sendByte(8'h55); sendByte(8'h06); sendByte(8'h00); sendByte(8'h7E);
    readByte(got); sendByte(8'h5A); pulseStrobe(); mStat[6] = 8'h7E;
    readByte(got);
    sendByte(8'h12);
    readByte(got); check("R8 CRC for byte 7", got, crcB(8'h07, 8'h12));
    sendByte(8'h5A); pulseStrobe();
    readByte(got); check("R9 status 7 stays 00h", got, 8'h00);
    sendByte(8'h00);
    readByte(got); check("R6 status address past end reply", got, 8'hFF);
    pulseBusReset();
    sendByte(8'h55); sendByte(8'h08); sendByte(8'h00); sendByte(8'h00);
    readByte(got); check("R6 status address 8 rejected", got, 8'hFF);
    pulseBusReset();
    compareStat("R9 status array after byte 7 attempts");

    // R5 protect page 1, R10 stray strobe on status path
    sendByte(8'h55); sendByte(8'h00); sendByte(8'h00); sendByte(8'hFD);
    readByte(got); pulseStrobe();
    compareStat("R10 strobe before program byte ignored");
    sendByte(8'h5A); pulseStrobe(); mStat[0] = 8'hFD;
    readByte(got); check("R5 lock bit read-back", got, 8'hFD);
    pulseBusReset();
    memWrite(8'h28, 64'h0, 0);
    compareMem("R5 locked page unchanged and readable");
    memWrite(8'h68, 64'h0, 0);
    compareMem("R5 unlocked page still programs");
    check("R5 locked page read", mMem[8'h28] == 8'h00 ? 8'h01 : 8'h00, 8'h00);

    finishRun();
  end
endmodule